// File: doc/BRIEF.md
# Homogeneous Vertex Transform Unit

This block moves vertices from their model space into a common space. It multiplies each incoming vertex by a 4x4 matrix held in an internal register bank. A per-vertex tag selects the kind of input. A position is given a fourth coordinate of one, so the translation terms in the last matrix column move it. A direction is given a fourth coordinate of zero, so the translation terms drop out. All values are signed Q16.16 fixed point.

The four dot products, one per matrix row, are formed together in four parallel lanes. The results are registered. A per-vertex flag can then request a perspective divide, which returns each of x, y and z divided by the computed w. This divide uses a bit-serial divider. Matrix elements are written one at a time by row and column index. Writes are accepted only while the pipeline is empty. Vertices enter on a valid/ready stream and leave, in order, on a second valid/ready stream.

Top module: `vtx_xform_unit`

## Requirements
- R1: A vertex with `in_is_dir` = 0 is extended with w = 1.0 (0x00010000), so column 3 of rows 0 to 2 adds a translation to its x, y and z results.
- R2: A vertex with `in_is_dir` = 1 is extended with w = 0, so matrix column 3 has no effect on any of its results. With the reset matrix, its output w is 0.
- R3: Output component r is the sum over c of round(M[r][c] * v[c]). Each product is rounded to Q16.16 by adding 2^15 to the 64-bit product and then shifting right arithmetically by 16. Row r produces x, y, z, w for r = 0, 1, 2, 3.
- R4: When a row sum falls outside the signed 32-bit range, the result saturates to 0x7FFFFFFF or to 0x80000000.
- R5: When `in_persp` = 1 and the computed w is nonzero, each of x, y and z becomes (component * 2^16) / w. The quotient is truncated toward zero and saturated to the signed 32-bit range. Output w is then 1.0 (0x00010000).
- R6: When the computed w is 0, the divide is skipped even if `in_persp` = 1. The raw x, y and z are output, and w is output as 0.
- R7: A matrix write stores `mat_data` at row `mat_row` and column `mat_col`. It takes effect on the next accepted vertex. `mat_rdy` is high exactly when every accepted vertex has already been delivered. A write presented while `mat_rdy` is low is dropped.
- R8: Outputs appear in input order with no loss or duplication. While `out_valid` is high and `out_ready` is low, the output data and `out_valid` hold.
- R9: After reset, `out_valid` is 0, `in_ready` is 1 and `mat_rdy` is 1. The matrix holds the identity, with 1.0 on the diagonal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mat_we | input | 1 | Matrix element write strobe |
| mat_row | input | 2 | Row index of the element written |
| mat_col | input | 2 | Column index of the element written |
| mat_data | input | 32 | Q16.16 element value |
| mat_rdy | output | 1 | High when the pipeline is empty and writes are taken |
| in_valid | input | 1 | Input vertex valid |
| in_ready | output | 1 | Input vertex can be accepted |
| in_x | input | 32 | Vertex x, Q16.16 |
| in_y | input | 32 | Vertex y, Q16.16 |
| in_z | input | 32 | Vertex z, Q16.16 |
| in_is_dir | input | 1 | 1 = direction (w = 0), 0 = position (w = 1) |
| in_persp | input | 1 | Request the divide by w |
| out_valid | output | 1 | Output vertex valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_x | output | 32 | Result x, Q16.16 |
| out_y | output | 32 | Result y, Q16.16 |
| out_z | output | 32 | Result z, Q16.16 |
| out_w | output | 32 | Result w, Q16.16 |

## Verification
The bench first sends positions and directions through an identity matrix and then through a translation matrix. Any mix-up in how w is extended therefore shows directly as a missing or unwanted offset. Single-element fractional matrices at plus and minus odd least significant bits separate correct rounding from truncation. Near-full-scale elements drive the row sums into both rails.

A projection row that copies z into w checks the divide with positive w, negative w, a tiny w that saturates the quotient, and a zero w that must bypass the divide. A random stream that mixes tags and flags, run under random output stalls, then checks ordering, holding and the emptiness flag. A write attempted during a long divide must leave the matrix unchanged.

// File: rtl/vxf_pkg.sv
package vxf_pkg;
  // Lanes per dot product and rows per matrix (homogeneous 4-space).
  localparam int NCOMP = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIV,
    ST_FULL
  } stage_t;
endpackage

// File: rtl/vxf_dot4.sv
// One matrix row times the extended vertex: four rounded products summed with saturation.
module vxf_dot4 #(
  parameter int W    = 32,
  parameter int FRAC = 16
) (
  input  logic [3:0][W-1:0] row,
  input  logic [3:0][W-1:0] vec,
  output logic [W-1:0]      res
);
  localparam int PW = 2 * W;
  localparam int AW = PW + 2;
  localparam logic signed [PW-1:0] HALF = PW'(1) << (FRAC - 1);
  localparam logic signed [AW-1:0] HI   = (AW'(1) << (W - 1)) - AW'(1);
  localparam logic signed [AW-1:0] LO   = ~HI;

  logic signed [PW-1:0] prod [4];
  logic signed [PW-1:0] rnd  [4];
  logic signed [AW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < 4; i++) begin
      prod[i] = $signed(row[i]) * $signed(vec[i]);
      rnd[i]  = (prod[i] + HALF) >>> FRAC;
      acc     = acc + {{2{rnd[i][PW-1]}}, rnd[i]};
    end
    if (acc > HI)      res = HI[W-1:0];
    else if (acc < LO) res = LO[W-1:0];
    else               res = acc[W-1:0];
  end
endmodule

// File: rtl/vxf_serdiv.sv
// Restoring divider, one quotient bit per step; magnitudes only.
module vxf_serdiv #(
  parameter int DW = 32,
  parameter int NB = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          step,
  input  logic [NB-1:0] num,
  input  logic [DW-1:0] den,
  output logic [NB-1:0] quo_nxt
);
  logic [DW-1:0] rem_q, rem_d;
  logic [NB-1:0] qn_q, qn_d;
  logic [DW:0]   trial;
  logic          ge;

  always_comb begin
    trial   = {rem_q, qn_q[NB-1]};
    ge      = trial >= {1'b0, den};
    quo_nxt = {qn_q[NB-2:0], ge};
    rem_d   = rem_q;
    qn_d    = qn_q;
    if (ld) begin
      rem_d = '0;
      qn_d  = num;
    end else if (step) begin
      rem_d = ge ? DW'(trial - {1'b0, den}) : trial[DW-1:0];
      qn_d  = quo_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      qn_q  <= '0;
    end else begin
      rem_q <= rem_d;
      qn_q  <= qn_d;
    end
  end
endmodule

// File: rtl/vxf_divstage.sv
// Output stage: passes results through or divides x, y, z by w in sequence.
module vxf_divstage
  import vxf_pkg::*;
#(
  parameter int W    = 32,
  parameter int FRAC = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_v,
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_y,
  input  logic [W-1:0] in_z,
  input  logic [W-1:0] in_w,
  input  logic         in_persp,
  output logic         in_take,
  output logic         busy,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_x,
  output logic [W-1:0] out_y,
  output logic [W-1:0] out_z,
  output logic [W-1:0] out_w
);
  localparam int NB = W + FRAC;
  localparam int CW = $clog2(NB);
  localparam logic [W-1:0]  ONE   = W'(1) << FRAC;
  localparam logic [W-1:0]  MAXV  = (W'(1) << (W - 1)) - W'(1);
  localparam logic [W-1:0]  MINV  = W'(1) << (W - 1);
  localparam logic [NB-1:0] LIM_P = (NB'(1) << (W - 1)) - NB'(1);
  localparam logic [NB-1:0] LIM_N = NB'(1) << (W - 1);

  function automatic logic [W-1:0] mag(input logic [W-1:0] v);
    return v[W-1] ? (~v + W'(1)) : v;
  endfunction

  stage_t        st_q, st_d;
  logic [W-1:0]  x_q, x_d, y_q, y_d, z_q, z_d, w_q, w_d;
  logic [W-1:0]  den_q, den_d;
  logic          wneg_q, wneg_d;
  logic [2:0]    sgn_q, sgn_d;
  logic [1:0]    comp_q, comp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  logic          need_div, can_take, last, neg, cur_sgn;
  logic          div_ld, div_step;
  logic [NB-1:0] div_num, quo;
  logic [W-1:0]  qres;

  vxf_serdiv #(.DW(W), .NB(NB)) u_div (
    .clk(clk), .rst_n(rst_n), .ld(div_ld), .step(div_step),
    .num(div_num), .den(den_q), .quo_nxt(quo)
  );

  always_comb begin
    need_div = in_persp && (in_w != '0);
    can_take = (st_q == ST_IDLE) || ((st_q == ST_FULL) && out_ready);
    in_take  = in_v && can_take;
    last     = cnt_q == CW'(NB - 1);
    case (comp_q)
      2'd0:    cur_sgn = sgn_q[0];
      2'd1:    cur_sgn = sgn_q[1];
      default: cur_sgn = sgn_q[2];
    endcase
    neg = cur_sgn ^ wneg_q;
    if (neg) qres = (quo > LIM_N) ? MINV : (~quo[W-1:0] + W'(1));
    else     qres = (quo > LIM_P) ? MAXV : quo[W-1:0];
  end

  always_comb begin
    st_d = st_q; x_d = x_q; y_d = y_q; z_d = z_q; w_d = w_q;
    den_d = den_q; wneg_d = wneg_q; sgn_d = sgn_q; comp_d = comp_q; cnt_d = cnt_q;
    div_ld = 1'b0; div_step = 1'b0; div_num = '0;
    case (st_q)
      ST_IDLE, ST_FULL: begin
        if ((st_q == ST_FULL) && out_ready) st_d = ST_IDLE;
        if (in_take) begin
          x_d = in_x; y_d = in_y; z_d = in_z; w_d = in_w;
          sgn_d  = {in_z[W-1], in_y[W-1], in_x[W-1]};
          den_d  = mag(in_w);
          wneg_d = in_w[W-1];
          comp_d = '0;
          cnt_d  = '0;
          if (need_div) begin
            st_d    = ST_DIV;
            div_ld  = 1'b1;
            div_num = {mag(in_x), {FRAC{1'b0}}};
          end else begin
            st_d = ST_FULL;
          end
        end
      end
      ST_DIV: begin
        div_step = 1'b1;
        cnt_d    = cnt_q + CW'(1);
        if (last) begin
          cnt_d = '0;
          case (comp_q)
            2'd0:    x_d = qres;
            2'd1:    y_d = qres;
            default: z_d = qres;
          endcase
          if (comp_q == 2'd2) begin
            st_d = ST_FULL;
            w_d  = ONE;
          end else begin
            comp_d  = comp_q + 2'd1;
            div_ld  = 1'b1;
            div_num = {mag((comp_q == 2'd0) ? y_q : z_q), {FRAC{1'b0}}};
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      x_q <= '0; y_q <= '0; z_q <= '0; w_q <= '0;
      den_q <= '0; wneg_q <= 1'b0; sgn_q <= '0; comp_q <= '0; cnt_q <= '0;
    end else begin
      st_q <= st_d;
      x_q <= x_d; y_q <= y_d; z_q <= z_d; w_q <= w_d;
      den_q <= den_d; wneg_q <= wneg_d; sgn_q <= sgn_d; comp_q <= comp_d; cnt_q <= cnt_d;
    end
  end

  assign busy      = st_q != ST_IDLE;
  assign out_valid = st_q == ST_FULL;
  assign out_x     = x_q;
  assign out_y     = y_q;
  assign out_z     = z_q;
  assign out_w     = w_q;
endmodule

// File: rtl/vtx_xform_unit.sv
module vtx_xform_unit
  import vxf_pkg::*;
#(
  parameter int W    = 32,
  parameter int FRAC = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mat_we,
  input  logic [1:0]   mat_row,
  input  logic [1:0]   mat_col,
  input  logic [W-1:0] mat_data,
  output logic         mat_rdy,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_y,
  input  logic [W-1:0] in_z,
  input  logic         in_is_dir,
  input  logic         in_persp,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_x,
  output logic [W-1:0] out_y,
  output logic [W-1:0] out_z,
  output logic [W-1:0] out_w
);
  localparam logic [W-1:0] ONE = W'(1) << FRAC;

  logic [NCOMP-1:0][NCOMP-1:0][W-1:0] mat_q, mat_d;
  logic [NCOMP-1:0][W-1:0]            vec, dot;
  logic [NCOMP-1:0][W-1:0]            s1_q, s1_d;
  logic                               s1_v_q, s1_v_d, s1_p_q, s1_p_d;
  logic                               wr_en, acc_in, s2_take, s2_busy;

  // Matrix bank
  assign wr_en = mat_we && mat_rdy;

  always_comb begin
    mat_d = mat_q;
    if (wr_en) mat_d[mat_row][mat_col] = mat_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NCOMP; r++)
        for (int c = 0; c < NCOMP; c++)
          mat_q[r][c] <= (r == c) ? ONE : '0;
    end else if (wr_en) begin
      mat_q <= mat_d;
    end
  end

  // Homogeneous extension and four parallel row lanes
  always_comb begin
    vec[0] = in_x;
    vec[1] = in_y;
    vec[2] = in_z;
    vec[3] = in_is_dir ? '0 : ONE;
  end

  for (genvar r = 0; r < NCOMP; r++) begin : g_lane
    vxf_dot4 #(.W(W), .FRAC(FRAC)) u_lane (
      .row(mat_q[r]), .vec(vec), .res(dot[r])
    );
  end

  // Stage 1 register
  assign in_ready = !s1_v_q || s2_take;
  assign acc_in   = in_valid && in_ready;

  always_comb begin
    s1_d   = s1_q;
    s1_p_d = s1_p_q;
    s1_v_d = s1_v_q;
    if (s2_take) s1_v_d = 1'b0;
    if (acc_in) begin
      s1_v_d = 1'b1;
      s1_d   = dot;
      s1_p_d = in_persp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v_q <= 1'b0;
      s1_p_q <= 1'b0;
      s1_q   <= '0;
    end else begin
      s1_v_q <= s1_v_d;
      if (acc_in) begin
        s1_q   <= s1_d;
        s1_p_q <= s1_p_d;
      end
    end
  end

  assign mat_rdy = !s1_v_q && !s2_busy;

  vxf_divstage #(.W(W), .FRAC(FRAC)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_v(s1_v_q), .in_x(s1_q[0]), .in_y(s1_q[1]), .in_z(s1_q[2]), .in_w(s1_q[3]),
    .in_persp(s1_p_q), .in_take(s2_take), .busy(s2_busy),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y), .out_z(out_z), .out_w(out_w)
  );
endmodule

// File: rtl/vxf_checks.sv
module vxf_checks #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mat_rdy,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_x,
  input logic [W-1:0] out_y,
  input logic [W-1:0] out_z,
  input logic [W-1:0] out_w
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y)
                                && $stable(out_z) && $stable(out_w));

  assert_busy_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !mat_rdy);

  assert_accept_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !mat_rdy);

  assert_stall_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !mat_rdy);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_R9: assert (!out_valid && mat_rdy && in_ready);
    end
  end
endmodule

bind vtx_xform_unit vxf_checks #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mat_rdy(mat_rdy), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_x(out_x), .out_y(out_y), .out_z(out_z), .out_w(out_w)
);

// File: tb/sim_vtx_xform_unit.sv
module sim_vtx_xform_unit;
  localparam int CLK_PERIOD = 10;
  localparam int ONE = 65536;
  localparam longint LMAX = 64'sd2147483647;
  localparam longint LMIN = -64'sd2147483648;

  logic clk, rst_n;
  logic mat_we, mat_rdy;
  logic [1:0] mat_row, mat_col;
  logic [31:0] mat_data;
  logic in_valid, in_ready, in_is_dir, in_persp;
  logic [31:0] in_x, in_y, in_z;
  logic out_valid, out_ready;
  logic [31:0] out_x, out_y, out_z, out_w;

  vtx_xform_unit u0 (.*);

  typedef struct { int x; int y; int z; int w; } vtx_t;
  vtx_t  expq[$];
  string tagq[$];
  int    m [4][4];
  int    mm[4][4];
  int    checks = 0, errors = 0;
  bit    last_acc = 0, done = 0;
  int    stall_mode = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint rp(longint a, longint b);
    longint p = a * b;
    return (p + 64'sd32768) >>> 16;
  endfunction

  function automatic int sat(longint s);
    if (s > LMAX) return int'(LMAX);
    if (s < LMIN) return int'(LMIN);
    return int'(s);
  endfunction

  function automatic int qdiv(longint a, longint w);
    longint ma = (a < 0) ? -a : a;
    longint mw = (w < 0) ? -w : w;
    longint q  = (ma <<< 16) / mw;
    if ((a < 0) != (w < 0)) return (q > -LMIN) ? int'(LMIN) : int'(-q);
    return (q > LMAX) ? int'(LMAX) : int'(q);
  endfunction

  function automatic vtx_t model(int x, int y, int z, bit dir, bit persp);
    longint v[4];
    int s[4];
    vtx_t r;
    v[0] = x; v[1] = y; v[2] = z; v[3] = dir ? 0 : ONE;
    for (int i = 0; i < 4; i++) begin
      longint acc = 0;
      for (int c = 0; c < 4; c++) acc += rp(m[i][c], v[c]);
      s[i] = sat(acc);
    end
    if (persp && s[3] != 0) begin
      r.x = qdiv(s[0], s[3]); r.y = qdiv(s[1], s[3]); r.z = qdiv(s[2], s[3]); r.w = ONE;
    end else begin
      r.x = s[0]; r.y = s[1]; r.z = s[2]; r.w = s[3];
    end
    return r;
  endfunction

  string cur_tag = "R9";

  task automatic monitor();
    bit empty0 = (expq.size() == 0);
    checks++;
    if (mat_rdy !== empty0) begin
      errors++;
      $display("FAIL R7 mat_rdy got %0b expected %0b", mat_rdy, empty0);
    end
    if (out_valid && out_ready) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected output got %h expected none", out_x);
      end else begin
        vtx_t e = expq.pop_front();
        string t = tagq.pop_front();
        if (int'(out_x) != e.x || int'(out_y) != e.y || int'(out_z) != e.z || int'(out_w) != e.w) begin
          errors++;
          $display("FAIL %s got %h %h %h %h expected %h %h %h %h", t,
                   out_x, out_y, out_z, out_w, e.x, e.y, e.z, e.w);
        end
      end
    end
    last_acc = in_valid && in_ready;
    if (last_acc) begin
      expq.push_back(model(int'(in_x), int'(in_y), int'(in_z), in_is_dir, in_persp));
      tagq.push_back(cur_tag);
    end
    if (mat_we && empty0) m[mat_row][mat_col] = int'(mat_data);
  endtask

  task automatic tick();
    out_ready = (stall_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
    #1;
    monitor();
    @(negedge clk);
  endtask

  task automatic wr(int r, int c, int val);
    mat_we = 1; mat_row = 2'(r); mat_col = 2'(c); mat_data = val;
    tick();
    mat_we = 0;
  endtask

  task automatic load_mat();
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) wr(r, c, mm[r][c]);
  endtask

  task automatic ident();
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) mm[r][c] = (r == c) ? ONE : 0;
  endtask

  task automatic send(string tag, int x, int y, int z, bit dir, bit persp);
    cur_tag = tag;
    in_valid = 1; in_x = x; in_y = y; in_z = z; in_is_dir = dir; in_persp = persp;
    do tick(); while (!last_acc);
    in_valid = 0;
  endtask

  task automatic drain();
    for (int g = 0; g < 3000 && expq.size() > 0; g++) tick();
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clk = 0; rst_n = 0;
    mat_we = 0; mat_row = 0; mat_col = 0; mat_data = 0;
    in_valid = 0; in_x = 0; in_y = 0; in_z = 0; in_is_dir = 0; in_persp = 0; out_ready = 1;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) m[r][c] = (r == c) ? ONE : 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1 || mat_rdy !== 1'b1) begin
      errors++;
      $display("FAIL R9 reset got %b%b%b expected 011", out_valid, in_ready, mat_rdy);
    end
    @(negedge clk);

    // R9: identity matrix after reset
    send("R9", 98304, -131072, 196608, 0, 0);
    send("R9", 12345, 678, -9, 1, 0);
    drain();

    // R1 / R2: translation in column 3
    ident();
    mm[0][3] = 3 * ONE; mm[1][3] = -2 * ONE; mm[2][3] = ONE / 2; mm[0][1] = ONE / 4;
    load_mat();
    send("R1", ONE, 2 * ONE, 3 * ONE, 0, 0);
    send("R1", -98304, 0, 4 * ONE, 0, 0);
    send("R2", ONE, 2 * ONE, 3 * ONE, 1, 0);
    send("R2", -5 * ONE, 7, -ONE, 1, 0);
    drain();

    // R3: rounding of products
    ident();
    mm[0][0] = 32768;
    load_mat();
    send("R3", 1, 0, 0, 1, 0);
    send("R3", -1, 0, 0, 1, 0);
    send("R3", 3, 0, 0, 1, 0);
    send("R3", -3, 5, 7, 0, 0);
    drain();

    // R4: saturation of row sums
    ident();
    mm[0][0] = 32'h7FFF0000; mm[0][1] = 32'h7FFF0000;
    load_mat();
    send("R4", 30000 * ONE, 30000 * ONE, 0, 0, 0);
    send("R4", -30000 * ONE, -30000 * ONE, 0, 0, 0);
    drain();

    // R5 / R6: perspective divide with w taken from z
    ident();
    mm[3][2] = ONE; mm[3][3] = 0;
    load_mat();
    send("R5", 2 * ONE, 4 * ONE, 2 * ONE, 0, 1);
    send("R5", 3 * ONE, -5 * ONE, -2 * ONE, 0, 1);
    send("R5", 1000 * ONE, -7 * ONE, 1, 0, 1);
    send("R5", 32'h80000000, ONE, 2 * ONE, 1, 1);
    send("R6", 5 * ONE, 6 * ONE, 0, 0, 1);
    send("R6", ONE, ONE, 0, 1, 1);
    send("R5", 7 * ONE, 9 * ONE, 3 * ONE, 0, 0);
    drain();

    // R7: write during a divide is dropped
    send("R7", 6 * ONE, 3 * ONE, 3 * ONE, 0, 1);
    repeat (5) tick();
    wr(0, 0, 5 * ONE);
    drain();
    send("R7", 6 * ONE, 3 * ONE, 3 * ONE, 0, 1);
    drain();

    // R8: random stream under random back-pressure
    stall_mode = 1;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) mm[r][c] = int'($urandom % (4 * ONE)) - 2 * ONE;
    load_mat();
    for (int i = 0; i < 24; i++)
      send("R8", int'($urandom % (1 << 22)) - (1 << 21), int'($urandom % (1 << 22)) - (1 << 21),
           int'($urandom % (1 << 22)) - (1 << 21), 1'($urandom % 2), 1'(($urandom % 4) == 0));
    drain();
    stall_mode = 0;
    drain();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule